// File: doc/BRIEF.md
# Fast-Lock Charge Pump Current Selector

This block decides which of two charge-pump current codes reaches the charge pump. It holds a normal code and a boost code. The higher the code, the larger the pump current: the current is proportional to code + 1, so code 0 gives the minimum and code 7 gives eight times the minimum. A gain-select bit arrives with each load of the divider register. When that bit is 1 and the fast-mode field is `2'b11`, the boost code is driven only for a timed interval. The interval is counted in phase-detector cycles. When it ends, the block drives the normal code again and asks the register file to clear its copy of the gain-select bit. For any other fast-mode value, the gain-select bit is a plain static choice between the two codes.

The interval length is 3 + 4·T phase-detector cycles, where T is the 4-bit dwell field. This gives 3 to 63 cycles. A counter that advances only on the phase-detector tick measures it. A counter-reset request or a power-down request aborts any interval in progress and forces the normal code.

The control is a four-state machine:
- `ST_NORMAL` drives the normal code.
- `ST_HOLD_BOOST` drives the boost code with no time limit.
- `ST_DWELL` drives the boost code while the timer runs.
- `ST_RELEASE` is a one-cycle state that drives the normal code and emits the clear request.

The transitions are:
- **abort**: any state goes to `ST_NORMAL`.
- **load, gain 0**: goes to `ST_NORMAL`.
- **load, gain 1, fast mode 11**: goes to `ST_DWELL`, with the count restarted.
- **load, gain 1, other fast mode**: goes to `ST_HOLD_BOOST`.
- **expire**: `ST_DWELL` goes to `ST_RELEASE`.
- **retire**: `ST_RELEASE` goes to `ST_NORMAL`.

Abort has priority over load, and load has priority over expire.

Top module: `cp_fastlock_ctrl`

## Requirements
- R1: After reset, `cp_code_out` equals `cp_norm_code`, and `busy` and `gain_sel_clr` are 0.
- R2: A load with `gain_sel_in`=0 makes `cp_code_out` follow `cp_norm_code` from the next cycle, with `busy`=0.
- R3: A load with `gain_sel_in`=1 and `fast_mode` other than `2'b11` selects `cp_boost_code` from the next cycle, with `busy`=0. This selection lasts until the next load or abort, no matter how many ticks arrive.
- R4: A load with `gain_sel_in`=1 and `fast_mode`=`2'b11` selects `cp_boost_code` and raises `busy` from the next cycle.
- R5: The timed boost ends on the clock edge of the (3 + 4·`dwell_sel`)-th tick that arrives after the load edge. A tick on the load edge itself is not counted.
- R6: When the timed boost ends, `gain_sel_clr` is 1 for exactly one cycle, `busy` drops, and `cp_code_out` returns to `cp_norm_code`.
- R7: Cycles without `pfd_tick` do not advance the interval.
- R8: A load during a timed boost restarts the count from zero with the newly presented fields. A reload with gain 0 ends the boost at once, without a clear pulse.
- R9: While `cnt_clear` or `pwr_down` is high, the block drives `cp_norm_code` with `busy`=0 and `gain_sel_clr`=0 from the next cycle, and it ignores loads.
- R10: `fast_mode` and `dwell_sel` are sampled only on a load. Changing them during a boost has no effect.
- R11: The selected code passes through without delay: changes to the selected code input appear on `cp_code_out` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_norm_code | input | 3 | Normal charge-pump current code |
| cp_boost_code | input | 3 | Boost charge-pump current code |
| fast_mode | input | 2 | Fast-lock mode field; `2'b11` enables the timed boost |
| dwell_sel | input | 4 | Dwell field T; interval length is 3 + 4·T ticks |
| gain_sel_in | input | 1 | Gain-select bit written with the divider register |
| nreg_load | input | 1 | One-cycle strobe marking a divider register load |
| pfd_tick | input | 1 | One pulse per phase-detector cycle |
| cnt_clear | input | 1 | Counter reset request; aborts the boost |
| pwr_down | input | 1 | Power-down request; aborts the boost |
| cp_code_out | output | 3 | Active current code to the charge pump |
| gain_sel_clr | output | 1 | One-cycle request to clear the stored gain-select bit |
| busy | output | 1 | High while the timed boost interval runs |

## Verification
The bench targets the following corner cases:
- **Interval length.** It measures the length at the shortest setting (3), at the longest setting (63), and with sparse ticks. An off-by-one counter would show a boost one tick too long or too short. A design that counts clock cycles instead of ticks would end the boost early.
- **Load-edge tick.** It places a tick on the load edge itself. A design that counts that tick would end one tick early.
- **Reloads.** It reloads in the middle of an interval, both with gain 1 and with gain 0. A missed restart shows up as a short second interval. A spurious clear pulse shows up on the gain-0 reload.
- **Aborts.** It asserts each abort input while a load is presented, and changes the mode and dwell fields during a running boost. A design that lets loads through during an abort, or that reads the fields live, would leave the boost code driving or stretch the interval.

// File: rtl/cpfl_pkg.sv
package cpfl_pkg;

    // Control states of the fast-lock selector.
    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_HOLD_BOOST = 2'd1,
        ST_DWELL      = 2'd2,
        ST_RELEASE    = 2'd3
    } cpfl_state_e;

    localparam int          MODE_W     = 2;
    localparam logic [1:0]  FAST_TIMED = 2'b11;

endpackage

// File: rtl/cpfl_dwell_timer.sv
module cpfl_dwell_timer #(
    parameter int DWELL_W    = 4,
    parameter int DWELL_BASE = 3,
    parameter int DWELL_STEP = 4,
    localparam int MAX_LEN   = DWELL_BASE + DWELL_STEP * ((1 << DWELL_W) - 1),
    localparam int CNT_W     = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               halt,
    input  logic               run,
    input  logic               tick,
    input  logic [DWELL_W-1:0] dwell_field,
    output logic               expire
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] len_new;
    logic             at_last;

    // Interval length for the presented dwell field.
    always_comb begin
        len_new = CNT_W'(DWELL_BASE + DWELL_STEP * int'(dwell_field));
    end

    assign at_last = (count_q == (target_q - CNT_W'(1)));
    assign expire  = run && tick && at_last && !start && !halt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            target_q <= CNT_W'(DWELL_BASE);
        end else if (halt) begin
            count_q  <= '0;
        end else if (start) begin
            count_q  <= '0;
            target_q <= len_new;
        end else if (expire) begin
            count_q  <= '0;
        end else if (run && tick) begin
            count_q  <= count_q + CNT_W'(1);
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count_q < target_q)); // R5

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !start && !halt) |=> $stable(count_q)); // R7

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !halt) |=> (count_q == '0)); // R8

endmodule

// File: rtl/cpfl_ctrl_fsm.sv
module cpfl_ctrl_fsm
    import cpfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              gain_wr,
    input  logic [MODE_W-1:0] fast_mode,
    input  logic              abort,
    input  logic              expire,
    output logic              start,
    output logic              halt,
    output logic              run,
    output logic              use_boost,
    output logic              gain_clr
);

    cpfl_state_e state_q;
    cpfl_state_e state_d;
    logic        timed_req;

    assign timed_req = load && gain_wr && (fast_mode == FAST_TIMED) && !abort;
    assign start     = timed_req;
    assign halt      = abort || (load && !timed_req);

    // Next-state selection: abort, then load, then the state's own move.
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_NORMAL;
        end else if (load) begin
            if (!gain_wr)
                state_d = ST_NORMAL;
            else if (fast_mode == FAST_TIMED)
                state_d = ST_DWELL;
            else
                state_d = ST_HOLD_BOOST;
        end else begin
            unique case (state_q)
                ST_NORMAL:     state_d = ST_NORMAL;
                ST_HOLD_BOOST: state_d = ST_HOLD_BOOST;
                ST_DWELL:      state_d = expire ? ST_RELEASE : ST_DWELL;
                ST_RELEASE:    state_d = ST_NORMAL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_NORMAL;
        else
            state_q <= state_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        use_boost = 1'b0;
        run       = 1'b0;
        gain_clr  = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                use_boost = 1'b0;
            end
            ST_HOLD_BOOST: begin
                use_boost = 1'b1;
            end
            ST_DWELL: begin
                use_boost = 1'b1;
                run       = 1'b1;
            end
            ST_RELEASE: begin
                gain_clr  = 1'b1;
            end
        endcase
    end

    AST_ABORT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!use_boost && !run && !gain_clr)); // R9

    AST_CLR_AFTER_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clr |-> $past(run)); // R6

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clr |=> !gain_clr); // R6

    AST_TIMED_START: assert property (@(posedge clk) disable iff (!rst_n)
        timed_req |=> (run && use_boost)); // R4

    AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gain_wr && !abort && fast_mode != FAST_TIMED) |=> (use_boost && !run)); // R3

    AST_GAIN0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !gain_wr && !abort) |=> (!use_boost && !run && !gain_clr)); // R2

endmodule

// File: rtl/cpfl_code_mux.sv
module cpfl_code_mux #(
    parameter int CODE_W = 3
) (
    input  logic              sel_boost,
    input  logic [CODE_W-1:0] norm_code,
    input  logic [CODE_W-1:0] boost_code,
    output logic [CODE_W-1:0] code_out
);

    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_bit
        assign code_out[gi] = sel_boost ? boost_code[gi] : norm_code[gi];
    end

endmodule

// File: rtl/cp_fastlock_ctrl.sv
module cp_fastlock_ctrl
    import cpfl_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int DWELL_W    = 4,
    parameter int DWELL_BASE = 3,
    parameter int DWELL_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cp_norm_code,
    input  logic [CODE_W-1:0] cp_boost_code,
    input  logic [1:0]        fast_mode,
    input  logic [DWELL_W-1:0] dwell_sel,
    input  logic              gain_sel_in,
    input  logic              nreg_load,
    input  logic              pfd_tick,
    input  logic              cnt_clear,
    input  logic              pwr_down,
    output logic [CODE_W-1:0] cp_code_out,
    output logic              gain_sel_clr,
    output logic              busy
);

    logic abort;
    logic start;
    logic halt;
    logic run;
    logic expire;
    logic use_boost;

    assign abort = cnt_clear || pwr_down;
    assign busy  = run;

    cpfl_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (nreg_load),
        .gain_wr   (gain_sel_in),
        .fast_mode (fast_mode),
        .abort     (abort),
        .expire    (expire),
        .start     (start),
        .halt      (halt),
        .run       (run),
        .use_boost (use_boost),
        .gain_clr  (gain_sel_clr)
    );

    cpfl_dwell_timer #(
        .DWELL_W    (DWELL_W),
        .DWELL_BASE (DWELL_BASE),
        .DWELL_STEP (DWELL_STEP)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .halt        (halt),
        .run         (run),
        .tick        (pfd_tick),
        .dwell_field (dwell_sel),
        .expire      (expire)
    );

    cpfl_code_mux #(
        .CODE_W (CODE_W)
    ) u_mux (
        .sel_boost  (use_boost),
        .norm_code  (cp_norm_code),
        .boost_code (cp_boost_code),
        .code_out   (cp_code_out)
    );

    AST_BUSY_DRIVES_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cp_code_out == cp_boost_code)); // R11

    AST_CLR_DRIVES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        gain_sel_clr |-> (cp_code_out == cp_norm_code)); // R6

endmodule

// File: tb/sim_cp_fastlock_ctrl.sv
module sim_cp_fastlock_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] norm_c;
    logic [2:0] boost_c;
    logic [1:0] fmode;
    logic [3:0] dsel;
    logic       gain;
    logic       load;
    logic       tick;
    logic       cclr;
    logic       pdn;
    logic [2:0] code;
    logic       clr;
    logic       busy;

    always #2 clk = ~clk;

    cp_fastlock_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cp_norm_code  (norm_c),
        .cp_boost_code (boost_c),
        .fast_mode     (fmode),
        .dwell_sel     (dsel),
        .gain_sel_in   (gain),
        .nreg_load     (load),
        .pfd_tick      (tick),
        .cnt_clear     (cclr),
        .pwr_down      (pdn),
        .cp_code_out   (code),
        .gain_sel_clr  (clr),
        .busy          (busy)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";
    bit    done = 1'b0;
    // Model state: 0 normal, 1 static boost, 2 timed boost, 3 release.
    int    m_st = 0;
    int    m_cnt = 0;
    int    m_len = 3;

    function automatic int dwell_len(int t);
        return 3 + 4 * t;
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
        end else if (cclr || pdn) begin
            m_st = 0; m_cnt = 0;
        end else if (load) begin
            if (!gain) m_st = 0;
            else if (fmode == 2'b11) begin
                m_st = 2; m_cnt = 0; m_len = dwell_len(int'(dsel));
            end else m_st = 1;
        end else if (m_st == 2) begin
            if (tick) begin
                if (m_cnt == m_len - 1) begin m_st = 3; m_cnt = 0; end
                else m_cnt++;
            end
        end else if (m_st == 3) begin
            m_st = 0;
        end
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_model();
        logic [2:0] e_code;
        e_code = (m_st == 1 || m_st == 2) ? boost_c : norm_c;
        n_chk++;
        if (code !== e_code || busy !== (m_st == 2) || clr !== (m_st == 3)) begin
            n_fail++;
            $display("FAIL %s: actual code=%0d busy=%0d clr=%0d expected code=%0d busy=%0d clr=%0d",
                     phase, code, busy, clr, e_code, (m_st == 2), (m_st == 3));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_model();
    endtask

    task automatic do_load(logic g, logic [1:0] m, logic [3:0] t);
        gain = g; fmode = m; dsel = t; load = 1'b1;
        cyc();
        load = 1'b0;
    endtask

    task automatic run_ticks(int n, int per);
        for (int i = 0; i < n; i++) begin
            tick = ((i % per) == per - 1);
            cyc();
        end
        tick = 1'b0;
    endtask

    // Count ticks applied while busy until the interval ends.
    task automatic count_busy(int per, output int ticks);
        int k;
        ticks = 0; k = 0;
        while (busy && k < 2000) begin
            tick = ((k % per) == per - 1);
            if (tick) ticks++;
            cyc();
            k++;
        end
        tick = 1'b0;
    endtask

    initial begin
        int got;
        rst_n = 1'b0; norm_c = 3'd2; boost_c = 3'd6; fmode = 2'b00; dsel = 4'd0;
        gain = 1'b0; load = 1'b0; tick = 1'b0; cclr = 1'b0; pdn = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 code", int'(code), 2);
        check("R1 busy", int'(busy), 0);
        check("R1 clr", int'(clr), 0);
        rst_n = 1'b1;
        cyc();

        phase = "R2";
        do_load(1'b0, 2'b11, 4'd5);
        check("R2 code", int'(code), 2);
        run_ticks(5, 1);

        phase = "R4";
        tick = 1'b1;
        do_load(1'b1, 2'b11, 4'd0);
        tick = 1'b0;
        check("R4 busy", int'(busy), 1);
        check("R4 code", int'(code), 6);
        phase = "R5";
        count_busy(1, got);
        check("R5 len T=0 with load-edge tick", got, 3);
        phase = "R6";
        check("R6 clr pulse", int'(clr), 1);
        check("R6 code normal", int'(code), 2);
        cyc();
        check("R6 clr single", int'(clr), 0);

        phase = "R7";
        do_load(1'b1, 2'b11, 4'd1);
        count_busy(3, got);
        check("R7 sparse ticks T=1", got, 7);
        cyc();

        phase = "R5";
        do_load(1'b1, 2'b11, 4'd15);
        count_busy(2, got);
        check("R5 len T=15", got, 63);
        cyc();

        phase = "R8";
        do_load(1'b1, 2'b11, 4'd2);
        run_ticks(5, 1);
        do_load(1'b1, 2'b11, 4'd0);
        count_busy(1, got);
        check("R8 restart count", got, 3);
        cyc();
        do_load(1'b1, 2'b11, 4'd5);
        run_ticks(4, 1);
        do_load(1'b0, 2'b11, 4'd5);
        check("R8 gain0 reload busy", int'(busy), 0);
        check("R8 gain0 reload clr", int'(clr), 0);

        phase = "R9";
        do_load(1'b1, 2'b11, 4'd3);
        run_ticks(3, 1);
        cclr = 1'b1;
        cyc();
        check("R9 cnt_clear busy", int'(busy), 0);
        check("R9 cnt_clear code", int'(code), 2);
        do_load(1'b1, 2'b01, 4'd0);
        check("R9 load ignored", int'(code), 2);
        cclr = 1'b0;
        do_load(1'b1, 2'b11, 4'd3);
        pdn = 1'b1;
        cyc();
        check("R9 pwr_down busy", int'(busy), 0);
        do_load(1'b1, 2'b11, 4'd0);
        check("R9 pwr_down load ignored", int'(busy), 0);
        check("R9 pwr_down clr", int'(clr), 0);
        pdn = 1'b0;
        cyc();

        phase = "R10";
        do_load(1'b1, 2'b11, 4'd1);
        fmode = 2'b00; dsel = 4'd15;
        count_busy(1, got);
        check("R10 fields latched", got, 7);
        cyc();

        phase = "R3";
        do_load(1'b1, 2'b10, 4'd0);
        run_ticks(100, 1);
        check("R3 static boost code", int'(code), 6);
        check("R3 static busy", int'(busy), 0);

        phase = "R11";
        do_load(1'b1, 2'b11, 4'd4);
        boost_c = 3'd1;
        #0.1;
        check("R11 live boost code", int'(code), 1);
        run_ticks(30, 1);
        norm_c = 3'd7;
        cyc();
        check("R11 live normal code", int'(code), 7);

        phase = "R5 random";
        void'($urandom(32'd24681));
        for (int i = 0; i < 8000; i++) begin
            load = ($urandom % 120) == 0;
            gain = ($urandom % 4) != 0;
            fmode = (($urandom % 2) == 0) ? 2'b11 : 2'($urandom);
            dsel = 4'($urandom);
            tick = ($urandom % 3) != 0;
            cclr = ($urandom % 400) == 0;
            pdn = ($urandom % 500) == 0;
            if (($urandom % 50) == 0) norm_c = 3'($urandom);
            if (($urandom % 50) == 0) boost_c = 3'($urandom);
            cyc();
        end
        load = 1'b0; tick = 1'b0; cclr = 1'b0; pdn = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule